// File: doc/BRIEF.md
# Line-Frequency One-Per-Minute Pulse Divider

This block turns a squared mains-frequency signal into one short pulse per minute. The line signal is asynchronous to the fast system clock. A small flop chain synchronizes it, and a registered detector turns each high-to-low transition into a single-cycle advance strobe. A 12-bit binary up counter steps on each strobe. It starts over when its next value has all four of bits 4, 9, 10 and 11 set (weights 16, 512, 1024 and 2048). The smallest value with all four bits set is 3600, so one pass spans 3600 falling edges. With a 60 Hz line that pass lasts exactly one minute.

The counter never holds the value 3600. On the strobe that would carry it there, the counter loads zero instead, and the output pulse is raised for that single system-clock cycle. Everything runs in one clock domain and uses a synchronous, active-high reset. The line input and the pulse output are plain level and strobe pins. There is no stream traffic, so the block has no valid/ready handshake and no back-pressure.

Top module: `mains_minute_pulse`

## Requirements
- R1: While reset is high, and in the cycle after it, pulse_o is 0 and the count is zero. After release, 3600 falling edges are needed before the first pulse.
- R2: Each high-to-low transition of line_i advances the count by exactly one, however long the line stays low. Rising transitions do not advance it.
- R3: With the default two synchronizer stages, pulse_o rises at the fourth rising clk_i edge after the clock cycle in which line_i fell, for the 3600th falling edge of a pass.
- R4: pulse_o is high for exactly one clk_i cycle per pass.
- R5: The count loads zero in the cycle the pulse is issued, so pulses recur every 3600 falling edges.
- R6: Counts that set only some of bits 4, 9, 10 and 11 (for example 16, 512, 1552 and 3584) produce no pulse. The count never reaches 3600 or above.
- R7: If line_i does not fall, the count holds its value and no pulse is produced, however long that lasts.
- R8: A reset applied mid-count restarts the pass. The next pulse comes on the 3600th falling edge after release.
- R9: Reset takes priority over a pending advance strobe. An edge that is in flight when reset is asserted is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the line frequency |
| rst_i | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Squared line-frequency signal, asynchronous to clk_i |
| pulse_o | output | 1 | One-cycle pulse, issued once every 3600 falling edges of line_i |

## Verification
The only visible output is pulse_o, so a wrong count shows up as a shifted pulse: it arrives some number of line periods early or late, and after a full pass the offset is exact. A decode that tests too few bits fires at an intermediate count such as 3584 or 1552, well before the 3600th edge. A missed clear either suppresses the following pulse or makes it come after 4096 edges instead of 3600. A strobe that repeats while the line stays low, or that fires on rising edges, shortens the pass, and holding the line still for a long time exposes it.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int unsigned CNT_W_DEF       = 12;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  // bits 4, 9, 10, 11 -> 16 + 512 + 1024 + 2048 = 3600
  localparam logic [CNT_W_DEF-1:0] TC_MASK_DEF = 12'hE10;

  typedef enum logic [1:0] {
    CNT_IDLE  = 2'b00,
    CNT_STEP  = 2'b01,
    CNT_WRAP  = 2'b10
  } cnt_action_e;
endpackage

// File: rtl/mpd_line_sync.sv
module mpd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[0] <= 1'b0;
          else       chain_q[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i) begin
          if (rst_i) chain_q[g] <= 1'b0;
          else       chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpd_fall_detect.sv
module mpd_fall_detect (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic fall_o
);
  logic hist_q;
  logic stb_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      hist_q <= level_i;
      stb_q  <= hist_q & ~level_i;
    end
  end

  assign fall_o = stb_q;
endmodule

// File: rtl/mpd_tc_counter.sv
module mpd_tc_counter
  import mpd_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter logic [CNT_W-1:0] TC_MASK = TC_MASK_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] next_val;
  logic             hit;
  logic             tc_q;
  cnt_action_e      action;

  assign next_val = count_q + 1'b1;
  // decode only the selected bits of the settled next value
  assign hit      = ((next_val & TC_MASK) == TC_MASK);

  always_comb begin
    action = CNT_IDLE;
    if (adv_i) action = hit ? CNT_WRAP : CNT_STEP;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q <= '0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      unique case (action)
        CNT_STEP: count_q <= next_val;
        CNT_WRAP: begin
          count_q <= '0;
          tc_q    <= 1'b1;
        end
        default:  count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
  assign tc_o    = tc_q;
endmodule

// File: rtl/mains_minute_pulse.sv
module mains_minute_pulse
  import mpd_pkg::*;
#(
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter logic [CNT_W-1:0] TC_MASK = TC_MASK_DEF
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic line_i,
  output logic pulse_o
);
  logic             line_sync;
  logic             fall_stb;
  logic [CNT_W-1:0] count;

  mpd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .async_i (line_i),
    .sync_o  (line_sync)
  );

  mpd_fall_detect u_fall (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .level_i (line_sync),
    .fall_o  (fall_stb)
  );

  mpd_tc_counter #(.CNT_W(CNT_W), .TC_MASK(TC_MASK)) u_cnt (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .adv_i   (fall_stb),
    .count_o (count),
    .tc_o    (pulse_o)
  );
endmodule

// File: rtl/mains_minute_pulse_chk.sv
module mains_minute_pulse_chk #(
  parameter int unsigned CNT_W = 12,
  parameter logic [CNT_W-1:0] TC_MASK = 12'hE10
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             stb_i,
  input logic [CNT_W-1:0] count_i,
  input logic             pulse_i
);
  assert_reset_clears_R1: assert property (@(posedge clk_i)
    rst_i |=> (count_i == '0 && !pulse_i));

  assert_pulse_follows_strobe_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(pulse_i) |-> $past(stb_i));

  assert_pulse_one_cycle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_i |=> !pulse_i);

  assert_pulse_with_clear_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_i |-> count_i == '0);

  assert_count_below_term_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    count_i < TC_MASK);

  assert_hold_without_edge_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !stb_i |=> $stable(count_i) && !pulse_i);
endmodule

bind mains_minute_pulse mains_minute_pulse_chk #(.CNT_W(CNT_W), .TC_MASK(TC_MASK)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .stb_i   (fall_stb),
  .count_i (count),
  .pulse_i (pulse_o)
);

// File: tb/mains_minute_pulse_bench.sv
module mains_minute_pulse_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  PASS_LEN   = 3600;
  localparam int  HALF_CYC   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line = 1'b1;
  logic pulse;

  int checks = 0;
  int errors = 0;
  int edges = 0;
  int pulses_seen = 0;
  bit done = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mains_minute_pulse u_mains_minute_pulse (
    .clk_i   (clk),
    .rst_i   (rst),
    .line_i  (line),
    .pulse_o (pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one line period, falling edge first; queue the expected pulse
  task automatic line_period();
    @(negedge clk);
    line = 1'b0;
    edges++;
    if (edges % PASS_LEN == 0) exp_q.push_back(edges);
    repeat (HALF_CYC) @(negedge clk);
    line = 1'b1;
    repeat (HALF_CYC - 1) @(negedge clk);
  endtask

  // monitor: scoreboard pop and compare; checks one-cycle width
  initial begin
    bit prev_p = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        prev_p = 1'b0;
      end else begin
        if (pulse) begin
          pulses_seen++;
          check(!prev_p, "R4 pulse width", 2, 1);
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected pulse at edge", edges, 0);
          end else begin
            int e;
            e = exp_q.pop_front();
            check(e == edges, "R3/R5 pulse edge index", edges, e);
          end
        end
        prev_p = pulse;
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    check(pulse == 1'b0, "R1 pulse low in reset", pulse, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pulse == 1'b0, "R1 pulse low after reset", pulse, 0);

    // first pass with intermediate-count checks (R6)
    base = pulses_seen;
    for (int i = 0; i < PASS_LEN - 1; i++) begin
      line_period();
      if (edges == 16 || edges == 512 || edges == 1552 || edges == 3584)
        check(pulses_seen == base, "R6 no pulse on partial decode", pulses_seen, base);
    end
    // hold line low, then high, for a long time at count 3599 (R2, R7)
    @(negedge clk);
    line = 1'b0;
    edges++;
    exp_q.push_back(edges);
    repeat (400) @(negedge clk);
    line = 1'b1;
    repeat (10) @(negedge clk);
    check(pulses_seen == base + 1, "R2 long low counted once", pulses_seen, base + 1);
    repeat (400) @(negedge clk);
    check(pulses_seen == base + 1, "R7 no pulse without edges", pulses_seen, base + 1);

    // two further passes (R5)
    for (int i = 0; i < 2 * PASS_LEN; i++) line_period();
    repeat (8) @(negedge clk);
    check(pulses_seen == base + 3, "R5 one pulse per pass", pulses_seen, base + 3);

    // mid-count reset with an edge in flight (R8, R9)
    for (int i = 0; i < 2000; i++) line_period();
    @(negedge clk);
    line = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R9 reset over pending edge", pulse, 0);
    rst = 1'b0;
    repeat (HALF_CYC) @(negedge clk);
    line = 1'b1;
    repeat (HALF_CYC) @(negedge clk);
    exp_q.delete();
    edges = 0;
    base = pulses_seen;
    for (int i = 0; i < PASS_LEN - 1; i++) line_period();
    repeat (8) @(negedge clk);
    check(pulses_seen == base, "R8 no early pulse after reset", pulses_seen, base);
    line_period();
    repeat (8) @(negedge clk);
    check(pulses_seen == base + 1, "R8 pulse after full pass", pulses_seen, base + 1);
    check(exp_q.size() == 0, "R3 all expected pulses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule